// File: doc/BRIEF.md
# Limited-Range Pixel Clamp

This block sits on a pixel stream carrying three 12-bit colour components (R, G, B) per beat. It forces each component into a legal code range when the output has to be limited-range video. A small control register holds an enable bit and a 3-bit range code. The code either names a fixed limited range for 8, 10 or 12 bits per component, or selects bounds that are held per component in six programmable registers. Every other combination of enable and code passes the pixel through unchanged.

The clamp adds exactly one register stage. The valid flag and a sideband field (for example start-of-frame or end-of-line markers) go through the same stage as the data, so downstream timing does not change with the mode. A write to the control register or to a bound register takes effect from the next clock edge. A pixel accepted on the same edge as the write is still processed with the settings held before that edge.

Top module: `pxclamp_top`

## Requirements
- R1: After reset the output valid is 0, the output data and sideband are 0, the enable bit and range code are 0, and every programmable bound is at lower = 0x010, upper = 0xFEF (12-bit scale).
- R2: While the enable bit is 0, every input pixel appears at the output unchanged, whatever the range code.
- R3: With the enable bit set and range code 0 (full range / 6 bpc), pixels pass through unchanged.
- R4: With the enable bit set, range codes 1, 2 and 3 (8, 10 and 12 bpc limited range) confine each component to the window 0x100..0xEB0. These are the limits 16..235, 64..940 and 256..3760, each aligned to the MSBs of the 12-bit datapath.
- R5: With the enable bit set and range code 7, each component is confined to its own programmable lower and upper bound.
- R6: In an active clamp mode, a component below the lower bound becomes the lower bound and a component above the upper bound becomes the upper bound. A component equal to a bound, or between the bounds, is unchanged.
- R7: Range codes 4, 5 and 6 pass pixels through unchanged, even with the enable bit set.
- R8: Output valid equals input valid one cycle earlier. The output data and sideband are the clamped input data and the input sideband from one cycle earlier. Output data and sideband hold their value on cycles that follow an input without valid.
- R9: A bound write selects the component with `bnd_comp` (0 = R, 1 = G, 2 = B) and the bound with `bnd_upper` (0 = lower, 1 = upper). A write with `bnd_comp` = 3 changes no bound.
- R10: A control or bound write takes effect on the clock edge that performs it. A pixel accepted on that same edge uses the previous settings, and pixels accepted on later edges use the new ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_en | input | 1 | Clamp enable value to write |
| cfg_fmt | input | 3 | Range code to write (0 off, 1/2/3 fixed, 7 programmable, 4-6 unused) |
| bnd_wr | input | 1 | Write strobe for one bound register |
| bnd_comp | input | 2 | Component select for bound write (0 R, 1 G, 2 B) |
| bnd_upper | input | 1 | 0 writes the lower bound, 1 the upper bound |
| bnd_val | input | DW (12) | Bound value to write |
| in_vld | input | 1 | Input pixel valid |
| in_sb | input | SBW (2) | Input sideband markers |
| in_r | input | DW (12) | Input red component |
| in_g | input | DW (12) | Input green component |
| in_b | input | DW (12) | Input blue component |
| out_vld | output | 1 | Output pixel valid |
| out_sb | output | SBW (2) | Delayed sideband markers |
| out_r | output | DW (12) | Clamped red component |
| out_g | output | DW (12) | Clamped green component |
| out_b | output | DW (12) | Clamped blue component |

## Verification
The assertions watch the pipeline on every cycle. They check the one-cycle delay of valid and sideband and the holding of data on idle cycles. They check that pixels pass through when the clamp is disabled or the code is 0, 4, 5 or 6, and that a fixed-range code never lets a component leave the 0x100..0xEB0 window or alters one already inside it. The exact replacement values, the reset values of the programmable bounds, the routing of each bound write to its component, the ignored component select 3 and the ordering of a write against a pixel on the same edge are shown only by the bench's scenarios.

// File: rtl/pxclamp_pkg.sv
package pxclamp_pkg;

   // number of colour components carried per pixel beat
   localparam int NCOMP = 3;

   // component index used by the bound write port
   localparam logic [1:0] COMP_R = 2'd0;
   localparam logic [1:0] COMP_G = 2'd1;
   localparam logic [1:0] COMP_B = 2'd2;

   // range code held in the control register
   typedef enum logic [2:0] {
      RNG_FULL = 3'd0,
      RNG_L8   = 3'd1,
      RNG_L10  = 3'd2,
      RNG_L12  = 3'd3,
      RNG_RSV4 = 3'd4,
      RNG_RSV5 = 3'd5,
      RNG_RSV6 = 3'd6,
      RNG_PROG = 3'd7
   } rng_code_e;

   // true for codes that request a limited range
   function automatic logic rng_is_limited(input logic [2:0] code);
      case (code)
         RNG_L8, RNG_L10, RNG_L12, RNG_PROG: rng_is_limited = 1'b1;
         default:                            rng_is_limited = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/pxclamp_regs.sv
module pxclamp_regs
   import pxclamp_pkg::*;
#(
   parameter int DW = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_wr,
   input  logic                       cfg_en,
   input  logic [2:0]                 cfg_fmt,
   input  logic                       bnd_wr,
   input  logic [1:0]                 bnd_comp,
   input  logic                       bnd_upper,
   input  logic [DW-1:0]              bnd_val,
   output logic                       en_q,
   output logic [2:0]                 fmt_q,
   output logic [NCOMP-1:0][DW-1:0]   lo_q,
   output logic [NCOMP-1:0][DW-1:0]   hi_q
);

   // reset bounds defined on a 12-bit scale, shifted up for wider paths
   localparam int                SHIFT  = DW - 12;
   localparam logic [DW-1:0]     LO_RST = DW'(32'h010) << SHIFT;
   localparam logic [DW-1:0]     HI_RST = DW'(32'hFEF) << SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         fmt_q <= 3'd0;
      end else if (cfg_wr) begin
         en_q  <= cfg_en;
         fmt_q <= cfg_fmt;
      end
   end

   for (genvar c = 0; c < NCOMP; c++) begin : g_bnd
      logic hit;
      assign hit = bnd_wr && (bnd_comp == 2'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[c] <= LO_RST;
            hi_q[c] <= HI_RST;
         end else if (hit) begin
            if (bnd_upper) hi_q[c] <= bnd_val;
            else           lo_q[c] <= bnd_val;
         end
      end
   end

endmodule

// File: rtl/pxclamp_limits.sv
module pxclamp_limits
   import pxclamp_pkg::*;
#(
   parameter int DW = 12
) (
   input  logic                       en,
   input  logic [2:0]                 fmt,
   input  logic [NCOMP-1:0][DW-1:0]   prog_lo,
   input  logic [NCOMP-1:0][DW-1:0]   prog_hi,
   output logic                       active,
   output logic [NCOMP-1:0][DW-1:0]   lo,
   output logic [NCOMP-1:0][DW-1:0]   hi
);

   // fixed limited-range bounds, MSB aligned to the DW-bit datapath
   localparam logic [DW-1:0] L8_LO  = DW'(32'd16)   << (DW - 8);
   localparam logic [DW-1:0] L8_HI  = DW'(32'd235)  << (DW - 8);
   localparam logic [DW-1:0] L10_LO = DW'(32'd64)   << (DW - 10);
   localparam logic [DW-1:0] L10_HI = DW'(32'd940)  << (DW - 10);
   localparam logic [DW-1:0] L12_LO = DW'(32'd256)  << (DW - 12);
   localparam logic [DW-1:0] L12_HI = DW'(32'd3760) << (DW - 12);

   if (DW < 12) begin : g_dw_too_small
      $error("pxclamp_limits: DW must be at least 12");
   end

   assign active = en && rng_is_limited(fmt);

   for (genvar c = 0; c < NCOMP; c++) begin : g_sel
      always_comb begin
         case (fmt)
            RNG_L8:   begin lo[c] = L8_LO;      hi[c] = L8_HI;      end
            RNG_L10:  begin lo[c] = L10_LO;     hi[c] = L10_HI;     end
            RNG_L12:  begin lo[c] = L12_LO;     hi[c] = L12_HI;     end
            RNG_PROG: begin lo[c] = prog_lo[c]; hi[c] = prog_hi[c]; end
            default:  begin lo[c] = '0;         hi[c] = '1;         end
         endcase
      end
   end

endmodule

// File: rtl/pxclamp_lane.sv
module pxclamp_lane #(
   parameter int DW = 12
) (
   input  logic          active,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);

   logic below;
   logic above;

   assign below = din < lo;
   assign above = din > hi;

   // lower bound wins if the bounds are programmed crossed
   always_comb begin
      if (!active)    dout = din;
      else if (below) dout = lo;
      else if (above) dout = hi;
      else            dout = din;
   end

endmodule

// File: rtl/pxclamp_top.sv
module pxclamp_top
   import pxclamp_pkg::*;
#(
   parameter int DW  = 12,
   parameter int SBW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_wr,
   input  logic           cfg_en,
   input  logic [2:0]     cfg_fmt,
   input  logic           bnd_wr,
   input  logic [1:0]     bnd_comp,
   input  logic           bnd_upper,
   input  logic [DW-1:0]  bnd_val,
   input  logic           in_vld,
   input  logic [SBW-1:0] in_sb,
   input  logic [DW-1:0]  in_r,
   input  logic [DW-1:0]  in_g,
   input  logic [DW-1:0]  in_b,
   output logic           out_vld,
   output logic [SBW-1:0] out_sb,
   output logic [DW-1:0]  out_r,
   output logic [DW-1:0]  out_g,
   output logic [DW-1:0]  out_b
);

   if (SBW < 1) begin : g_sbw_bad
      $error("pxclamp_top: SBW must be at least 1");
   end

   logic                       cfg_en_q;
   logic [2:0]                 cfg_fmt_q;
   logic [NCOMP-1:0][DW-1:0]   prog_lo;
   logic [NCOMP-1:0][DW-1:0]   prog_hi;
   logic                       clamp_on;
   logic [NCOMP-1:0][DW-1:0]   sel_lo;
   logic [NCOMP-1:0][DW-1:0]   sel_hi;
   logic [NCOMP-1:0][DW-1:0]   pix_in;
   logic [NCOMP-1:0][DW-1:0]   pix_cl;
   logic [NCOMP-1:0][DW-1:0]   pix_q;

   pxclamp_regs #(.DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_en    (cfg_en),
      .cfg_fmt   (cfg_fmt),
      .bnd_wr    (bnd_wr),
      .bnd_comp  (bnd_comp),
      .bnd_upper (bnd_upper),
      .bnd_val   (bnd_val),
      .en_q      (cfg_en_q),
      .fmt_q     (cfg_fmt_q),
      .lo_q      (prog_lo),
      .hi_q      (prog_hi)
   );

   pxclamp_limits #(.DW(DW)) u_limits (
      .en      (cfg_en_q),
      .fmt     (cfg_fmt_q),
      .prog_lo (prog_lo),
      .prog_hi (prog_hi),
      .active  (clamp_on),
      .lo      (sel_lo),
      .hi      (sel_hi)
   );

   assign pix_in[0] = in_r;
   assign pix_in[1] = in_g;
   assign pix_in[2] = in_b;

   for (genvar c = 0; c < NCOMP; c++) begin : g_lane
      pxclamp_lane #(.DW(DW)) u_lane (
         .active (clamp_on),
         .lo     (sel_lo[c]),
         .hi     (sel_hi[c]),
         .din    (pix_in[c]),
         .dout   (pix_cl[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_sb  <= '0;
         pix_q   <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_sb <= in_sb;
            pix_q  <= pix_cl;
         end
      end
   end

   assign out_r = pix_q[0];
   assign out_g = pix_q[1];
   assign out_b = pix_q[2];

endmodule

// File: rtl/pxclamp_chk.sv
module pxclamp_chk #(
   parameter int DW  = 12,
   parameter int SBW = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           en_q,
   input logic [2:0]     fmt_q,
   input logic           in_vld,
   input logic [SBW-1:0] in_sb,
   input logic [DW-1:0]  in_r,
   input logic [DW-1:0]  in_g,
   input logic [DW-1:0]  in_b,
   input logic           out_vld,
   input logic [SBW-1:0] out_sb,
   input logic [DW-1:0]  out_r,
   input logic [DW-1:0]  out_g,
   input logic [DW-1:0]  out_b
);

   localparam logic [DW-1:0] WLO = DW'(32'd16)  << (DW - 8);
   localparam logic [DW-1:0] WHI = DW'(32'd235) << (DW - 8);

   logic fixed_mode;
   logic pass_mode;
   assign fixed_mode = en_q && (fmt_q == 3'd1 || fmt_q == 3'd2 || fmt_q == 3'd3);
   assign pass_mode  = !en_q || fmt_q == 3'd0 || fmt_q == 3'd4 ||
                       fmt_q == 3'd5 || fmt_q == 3'd6;

   // R8: valid follows input valid by one cycle
   a_r8_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   a_r8_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);
   // R8: sideband travels with data
   a_r8_sb_delay: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_sb == $past(in_sb));
   // R8: outputs hold after an idle input cycle
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(out_r) && $stable(out_g) && $stable(out_b) && $stable(out_sb)));
   // R2, R3, R7: pass-through combinations
   a_r2_r3_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && pass_mode) |=>
         (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));
   // R4: fixed codes keep every component inside the window
   a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && fixed_mode) |=>
         (out_r >= WLO && out_r <= WHI && out_g >= WLO && out_g <= WHI &&
          out_b >= WLO && out_b <= WHI));
   // R6: an in-window component is left alone
   a_r6_keep_inside: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && fixed_mode && in_r >= WLO && in_r <= WHI) |=> out_r == $past(in_r));

endmodule

bind pxclamp_top pxclamp_chk #(.DW(DW), .SBW(SBW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_q    (cfg_en_q),
   .fmt_q   (cfg_fmt_q),
   .in_vld  (in_vld),
   .in_sb   (in_sb),
   .in_r    (in_r),
   .in_g    (in_g),
   .in_b    (in_b),
   .out_vld (out_vld),
   .out_sb  (out_sb),
   .out_r   (out_r),
   .out_g   (out_g),
   .out_b   (out_b)
);

// File: tb/test_pxclamp_top.sv
module test_pxclamp_top;

   localparam int DW  = 12;
   localparam int SBW = 2;
   localparam int NV  = 10;

   // {en, code, r, g, b, exp_r, exp_g, exp_b}
   localparam logic [75:0] VEC [NV] = '{
      {1'b0, 3'd1, 12'h000, 12'hFFF, 12'h800, 12'h000, 12'hFFF, 12'h800}, // R2
      {1'b1, 3'd0, 12'h000, 12'hFFF, 12'h123, 12'h000, 12'hFFF, 12'h123}, // R3
      {1'b1, 3'd1, 12'h000, 12'hFFF, 12'h800, 12'h100, 12'hEB0, 12'h800}, // R4
      {1'b1, 3'd2, 12'h0FF, 12'hEB1, 12'h100, 12'h100, 12'hEB0, 12'h100}, // R4 R6
      {1'b1, 3'd3, 12'h100, 12'hEB0, 12'h0FF, 12'h100, 12'hEB0, 12'h100}, // R4 R6
      {1'b1, 3'd4, 12'h000, 12'hFFF, 12'h005, 12'h000, 12'hFFF, 12'h005}, // R7
      {1'b1, 3'd5, 12'h001, 12'hFFE, 12'hF00, 12'h001, 12'hFFE, 12'hF00}, // R7
      {1'b1, 3'd6, 12'h00A, 12'hFF0, 12'h0F0, 12'h00A, 12'hFF0, 12'h0F0}, // R7
      {1'b1, 3'd7, 12'h000, 12'hFFF, 12'h00F, 12'h010, 12'hFEF, 12'h010}, // R1 R5
      {1'b1, 3'd7, 12'h010, 12'hFEF, 12'h7FF, 12'h010, 12'hFEF, 12'h7FF}  // R5 R6
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_wr = 1'b0;
   logic           cfg_en = 1'b0;
   logic [2:0]     cfg_fmt = 3'd0;
   logic           bnd_wr = 1'b0;
   logic [1:0]     bnd_comp = 2'd0;
   logic           bnd_upper = 1'b0;
   logic [DW-1:0]  bnd_val = '0;
   logic           in_vld = 1'b0;
   logic [SBW-1:0] in_sb = '0;
   logic [DW-1:0]  in_r = '0;
   logic [DW-1:0]  in_g = '0;
   logic [DW-1:0]  in_b = '0;
   logic           out_vld;
   logic [SBW-1:0] out_sb;
   logic [DW-1:0]  out_r;
   logic [DW-1:0]  out_g;
   logic [DW-1:0]  out_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pxclamp_top #(.DW(DW), .SBW(SBW)) i_pxclamp_top (
      .clk (clk), .rst_n (rst_n),
      .cfg_wr (cfg_wr), .cfg_en (cfg_en), .cfg_fmt (cfg_fmt),
      .bnd_wr (bnd_wr), .bnd_comp (bnd_comp), .bnd_upper (bnd_upper), .bnd_val (bnd_val),
      .in_vld (in_vld), .in_sb (in_sb), .in_r (in_r), .in_g (in_g), .in_b (in_b),
      .out_vld (out_vld), .out_sb (out_sb), .out_r (out_r), .out_g (out_g), .out_b (out_b)
   );

   task automatic check_pix(input string req, input logic [DW-1:0] er,
                            input logic [DW-1:0] eg, input logic [DW-1:0] eb);
      n_chk++;
      if (out_r !== er || out_g !== eg || out_b !== eb) begin
         n_fail++;
         $display("FAIL %s: got %h %h %h expected %h %h %h", req, out_r, out_g, out_b, er, eg, eb);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic en, input logic [2:0] code);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_en = en; cfg_fmt = code;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic write_bnd(input logic [1:0] comp, input logic up, input logic [DW-1:0] v);
      @(negedge clk);
      bnd_wr = 1'b1; bnd_comp = comp; bnd_upper = up; bnd_val = v;
      @(negedge clk);
      bnd_wr = 1'b0;
   endtask

   // drives one pixel at a falling edge; result is sampled one falling edge later
   task automatic send_pix(input logic [DW-1:0] r, input logic [DW-1:0] g,
                           input logic [DW-1:0] b, input logic [SBW-1:0] sb);
      in_vld = 1'b1; in_sb = sb; in_r = r; in_g = g; in_b = b;
      @(negedge clk);
      in_vld = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state of the outputs
      check_bit("R1 out_vld", out_vld, 1'b0);
      check_pix("R1 data", 12'h000, 12'h000, 12'h000);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R1 R2 R3 R4 R5 R6 R7
      for (int i = 0; i < NV; i++) begin
         write_cfg(VEC[i][75], VEC[i][74:72]);
         send_pix(VEC[i][71:60], VEC[i][59:48], VEC[i][47:36], 2'b00);
         check_pix($sformatf("R4/R6 table %0d", i), VEC[i][35:24], VEC[i][23:12], VEC[i][11:0]);
      end

      // R9 R5: program distinct bounds per component
      write_bnd(2'd0, 1'b0, 12'h200);
      write_bnd(2'd0, 1'b1, 12'h300);
      write_bnd(2'd1, 1'b0, 12'h050);
      write_bnd(2'd1, 1'b1, 12'h060);
      write_bnd(2'd2, 1'b0, 12'h400);
      write_bnd(2'd2, 1'b1, 12'hC00);
      send_pix(12'h100, 12'h100, 12'hFFF, 2'b00);
      check_pix("R9 low clamp", 12'h200, 12'h060, 12'hC00);
      send_pix(12'hFFF, 12'h000, 12'h000, 2'b00);
      check_pix("R9 high clamp", 12'h300, 12'h050, 12'h400);

      // R9: component select 3 writes nothing
      write_bnd(2'd3, 1'b0, 12'hFFF);
      write_bnd(2'd3, 1'b1, 12'h000);
      send_pix(12'h100, 12'h100, 12'hFFF, 2'b00);
      check_pix("R9 select 3 ignored", 12'h200, 12'h060, 12'hC00);

      // R8: latency, sideband and hold
      send_pix(12'h250, 12'h055, 12'h500, 2'b10);
      check_bit("R8 out_vld", out_vld, 1'b1);
      check_bit("R8 sideband", out_sb == 2'b10, 1'b1);
      check_pix("R8 data", 12'h250, 12'h055, 12'h500);
      @(negedge clk);
      check_bit("R8 idle valid", out_vld, 1'b0);
      check_pix("R8 hold", 12'h250, 12'h055, 12'h500);

      // R10: a write on the same edge as a pixel applies from the next pixel
      write_cfg(1'b1, 3'd0);
      cfg_wr = 1'b1; cfg_en = 1'b1; cfg_fmt = 3'd1;
      send_pix(12'h000, 12'h000, 12'h000, 2'b01);
      cfg_wr = 1'b0;
      check_pix("R10 old setting", 12'h000, 12'h000, 12'h000);
      send_pix(12'h000, 12'h000, 12'h000, 2'b01);
      check_pix("R10 new setting", 12'h100, 12'h100, 12'h100);

      // R2: disable overrides the programmable code
      write_cfg(1'b0, 3'd7);
      send_pix(12'hFFF, 12'h000, 12'h001, 2'b00);
      check_pix("R2 disabled", 12'hFFF, 12'h000, 12'h001);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule